// File: doc/BRIEF.md
# Configurable SPI Master/Slave Port

This block is a serial peripheral port with a small register interface. A single 16-bit control word selects the role, clock polarity, clock phase, bit order, frame length, open-drain drive and baud rate. As master, the port generates the serial clock and shifts a frame out on the master-out line while it samples the master-in line. As slave, it follows an externally driven serial clock whenever its active-low select input is low.

Software configures the control word first and then sets the enable bit. In master mode, a write to the data register starts a transfer. In slave mode, the same write preloads the word that will be returned on the next frame. At the end of each frame a completion flag is set, and an interrupt is raised if interrupts are enabled. Software clears the flag by reading status and then accessing the data register.

The register map uses the low two address bits: 0 is control, 1 is status (bit 0 is the completion flag, bit 1 is busy), and 2 is data. The control bits, from 15 down to 8, are: interrupt enable, port enable, open-drain, master, clock polarity, clock phase, LSB-first and 16-bit size. Bits 7 to 0 hold the baud divisor.

Top module: `spi_port`

## Requirements
- R1: After reset the control register reads 16'h0400 (phase bit 10 set, all other bits clear). Status and data read 0, and `irq` is low.
- R2: While the enable bit (14) is 0, none of `sck_oe`, `mosi_oe` or `miso_oe` is asserted, and a data write starts no transfer.
- R3: With the port enabled as master, the serial clock rests at the polarity bit (11) between frames. Each of its half periods lasts exactly baud (bits 7..0) system clocks.
- R4: With the phase bit (10) at 0, data is sampled on the leading clock edge and changes on the trailing edge. With it at 1, data changes on the leading edge and is sampled on the trailing edge. A frame of N bits has exactly 2N clock edges.
- R5: With bit 9 at 1 the frame goes least significant bit first; with it at 0, most significant bit first. The same order applies to transmit and receive.
- R6: With bit 8 at 0 a frame is 8 bits and uses only the low byte of the data register, and the received value reads with its upper byte 0. With bit 8 at 1 a frame is 16 bits.
- R7: With the open-drain bit (13) at 1, an output pin is only ever driven low. A high level is produced by releasing the pin (`*_oe` low).
- R8: A baud value of 0 prevents any master transfer from starting.
- R9: At the end of a frame, status bit 0 is set and `irq` follows it when bit 15 is 1. A status read followed by a data register access clears the flag.
- R10: As slave, the port shifts on edges of `sck_in` only while `ss_n` is low. It samples `mosi_in`, drives `miso_out` with the preloaded word, and drives `miso_oe` only while selected.
- R11: Rewriting the control register with its current value during a transfer has no effect. Writing a different value while enabled aborts the transfer, which clears busy and leaves the flag unset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational from address) |
| irq | output | 1 | Transfer-complete interrupt |
| sck_out | output | 1 | Serial clock output value (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sck_in | input | 1 | External serial clock (slave) |
| ss_n | input | 1 | Active-low slave select |
| mosi_out | output | 1 | Master-out data value |
| mosi_oe | output | 1 | Master-out output enable |
| mosi_in | input | 1 | Master-out data seen by a slave |
| miso_in | input | 1 | Master-in data seen by a master |
| miso_out | output | 1 | Slave-out data value |
| miso_oe | output | 1 | Slave-out output enable |

## Verification
The assertions assume three things about the inputs. The control register is not rewritten on the same cycle as a data write. In slave mode, `sck_in` and `mosi_in` change slowly compared with the three-stage input synchronizer. The master-in line is stable at the system clock edge on which it is sampled. The stimulus meets these conditions in the following ways. Each bus access takes its own cycle. The slave sweep holds every serial clock half period for eight system clocks. The bench's slave model changes the master-in line only on the system clock falling edge after it sees a serial clock edge, which is well before the next sample edge.

// File: rtl/spi_port.sv
module spi_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq,
  output logic        sck_out,
  output logic        sck_oe,
  input  logic        sck_in,
  input  logic        ss_n,
  output logic        mosi_out,
  output logic        mosi_oe,
  input  logic        mosi_in,
  input  logic        miso_in,
  output logic        miso_out,
  output logic        miso_oe
);
  localparam logic [15:0] CTRL_RST = 16'h0400;

  logic [15:0] ctrl, sh, rsh, rxd;
  logic [7:0]  div;
  logic [4:0]  cnt;
  logic [2:0]  s_sck;
  logic [1:0]  s_ss, s_mosi;
  logic        busy, spif, armed;

  wire spie = ctrl[15], spe = ctrl[14], womp = ctrl[13], mstr = ctrl[12];
  wire cpol = ctrl[11], cpha = ctrl[10], lsbf = ctrl[9], size = ctrl[8];
  wire [7:0] baud = ctrl[7:0];

  wire wr_ctrl  = bus_en & bus_wr & (bus_addr == 2'd0);
  wire rd_stat  = bus_en & ~bus_wr & (bus_addr == 2'd1);
  wire acc_data = bus_en & (bus_addr == 2'd2);
  wire wr_data  = acc_data & bus_wr;
  wire abort    = wr_ctrl & spe & (bus_wdata != ctrl);

  wire slv   = spe & ~mstr & ~s_ss[1];
  wire ev_m  = mstr & busy & (div == baud - 8'd1);
  wire ev_s  = slv & (s_sck[2] ^ s_sck[1]);
  wire ev    = ev_m | ev_s;
  wire [4:0] last = size ? 5'd31 : 5'd15;
  wire is_last = (cnt == last);
  wire samp    = (cnt[0] == cpha);
  wire shft    = ~samp & (cnt != 5'd0) & ~is_last;
  wire rx_bit  = mstr ? miso_in : s_mosi[1];

  logic [15:0] rsh_nx, rsh_use, frame;
  always_comb begin
    rsh_nx  = lsbf ? {rx_bit, rsh[15:1]} : {rsh[14:0], rx_bit};
    rsh_use = samp ? rsh_nx : rsh;
    frame   = size ? rsh_use : (lsbf ? {8'h00, rsh_use[15:8]} : {8'h00, rsh_use[7:0]});
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctrl <= CTRL_RST;
    else if (wr_ctrl) ctrl <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s_sck <= '0; s_ss <= 2'b11; s_mosi <= '0;
    end else begin
      s_sck <= {s_sck[1:0], sck_in};
      s_ss <= {s_ss[0], ss_n};
      s_mosi <= {s_mosi[0], mosi_in};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; div <= '0;
    end else if (abort || !spe || (!mstr && !slv)) begin
      busy <= 1'b0; cnt <= '0; div <= '0;
    end else begin
      if (mstr && wr_data && !busy && baud != 8'd0) begin
        busy <= 1'b1; div <= '0;
      end else if (busy) div <= ev ? 8'd0 : div + 8'd1;
      if (ev) begin
        cnt <= is_last ? 5'd0 : cnt + 5'd1;
        if (is_last) busy <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh <= '0; rsh <= '0; rxd <= '0;
    end else begin
      if (wr_data && !busy && cnt == 5'd0) sh <= bus_wdata;
      else if (ev && shft) sh <= lsbf ? (sh >> 1) : (sh << 1);
      if (ev && samp) rsh <= rsh_nx;
      if (ev && is_last) rxd <= frame;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      spif <= 1'b0; armed <= 1'b0;
    end else if (ev && is_last) begin
      spif <= 1'b1; armed <= 1'b0;
    end else if (acc_data && armed) begin
      spif <= 1'b0; armed <= 1'b0;
    end else if (rd_stat && spif) armed <= 1'b1;

  wire tx_bit  = lsbf ? sh[0] : (size ? sh[15] : sh[7]);
  wire sck_lvl = cpol ^ cnt[0];
  wire m_drv   = spe & mstr;

  assign sck_out  = sck_lvl & ~womp;
  assign sck_oe   = m_drv & ~(womp & sck_lvl);
  assign mosi_out = tx_bit & ~womp;
  assign mosi_oe  = m_drv & ~(womp & tx_bit);
  assign miso_out = tx_bit & ~womp;
  assign miso_oe  = slv & ~(womp & tx_bit);
  assign irq      = spif & spie;

  always_comb
    case (bus_addr)
      2'd0:    bus_rdata = ctrl;
      2'd1:    bus_rdata = {14'h0, busy | (cnt != 5'd0), spif};
      2'd2:    bus_rdata = rxd;
      default: bus_rdata = 16'h0;
    endcase

  p_off_pins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !spe |-> !sck_oe && !mosi_oe && !miso_oe);
  p_idle_sck_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (spe && mstr && !busy && !womp) |-> sck_out == cpol);
  p_od_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    womp |-> !sck_out && !mosi_out && !miso_out);
  p_no_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> baud != 8'd0);
  p_flag_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spif) |-> $past(ev));
  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy && cnt == 5'd0);
endmodule

// File: tb/spi_port_bench.sv
module spi_port_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic bus_en = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic irq, sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe;
  logic sck_in = 0, ss_n = 1, mosi_in = 0, miso_r = 1;

  spi_port u_spi_port (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .sck_out(sck_out), .sck_oe(sck_oe), .sck_in(sck_in), .ss_n(ss_n),
    .mosi_out(mosi_out), .mosi_oe(mosi_oe), .mosi_in(mosi_in),
    .miso_in(miso_r), .miso_out(miso_out), .miso_oe(miso_oe));

  wire sck_line  = sck_oe  ? sck_out  : 1'b1;
  wire mosi_line = mosi_oe ? mosi_out : 1'b1;
  wire miso_line = miso_oe ? miso_out : 1'b1;

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int bpos(input bit lsb, input int n, input int i);
    return lsb ? i : n - 1 - i;
  endfunction

  // bench slave model for master tests
  bit m_on = 0, m_prev = 1, m_cpol, m_cpha, m_lsbf, m_gaperr;
  int m_n, m_baud, m_edges, m_e, m_samp, m_gap;
  logic [15:0] m_pat, m_cap;

  always @(negedge clk) begin
    bit cur, lead;
    int idx;
    cur = sck_line;
    if (cur != m_prev) begin
      if (m_on) begin
        if (m_edges > 0 && m_gap != m_baud) m_gaperr = 1;
        lead = (cur != m_cpol);
        if (lead ^ m_cpha) begin
          if (m_samp < m_n) m_cap[bpos(m_lsbf, m_n, m_samp)] = mosi_line;
          m_samp++;
        end else begin
          m_e++;
          idx = m_cpha ? m_e - 1 : m_e;
          if (idx > m_n - 1) idx = m_n - 1;
          miso_r = m_pat[bpos(m_lsbf, m_n, idx)];
        end
        m_edges++;
      end
      m_gap = 1;
    end else m_gap++;
    m_prev = cur;
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk); bus_en = 1; bus_wr = 0; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk); bus_en = 0;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(2'd1, v);
      if (!v[1]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic run_master(input bit cpol, cpha, lsbf, size, womp, input int baud,
                            input logic [15:0] tx, pat, input bit rewrite);
    logic [15:0] ctrl, v, mask;
    int n;
    n = size ? 16 : 8;
    mask = size ? 16'hFFFF : 16'h00FF;
    ctrl = {1'b1, 1'b1, womp, 1'b1, cpol, cpha, lsbf, size, 8'(baud)};
    wr(2'd0, ctrl);
    repeat (2) @(negedge clk);
    chk(sck_line == cpol, "R3 idle level", sck_line, cpol);
    m_pat = pat; m_cap = 0; m_n = n; m_baud = baud; m_cpol = cpol; m_cpha = cpha;
    m_lsbf = lsbf; m_edges = 0; m_e = 0; m_samp = 0; m_gaperr = 0;
    miso_r = pat[bpos(lsbf, n, 0)];
    m_on = 1;
    wr(2'd2, tx);
    if (rewrite) begin
      repeat (6) @(negedge clk);
      wr(2'd0, ctrl);
    end
    wait_idle();
    m_on = 0;
    chk(m_edges == 2 * n, "R4 edge count", m_edges, 2 * n);
    chk(!m_gaperr, "R3 half period", m_gaperr, 0);
    chk(m_cap == (tx & mask), rewrite ? "R11 same-value tx" : "R5/R6 tx bits", m_cap, tx & mask);
    chk(irq == 1'b1, "R9 irq set", irq, 1);
    rd(2'd1, v);
    chk(v[0] == 1'b1, "R9 flag set", v[0], 1);
    rd(2'd2, v);
    chk(v == (pat & mask), "R4 rx word", v, pat & mask);
    rd(2'd1, v);
    chk(v[0] == 1'b0 && !irq, "R9 flag cleared", v[0], 0);
  endtask

  task automatic run_slave(input bit cpol, cpha, lsbf, size, input logic [15:0] pre, mw);
    logic [15:0] v, got, mask;
    int n, p;
    n = size ? 16 : 8;
    mask = size ? 16'hFFFF : 16'h00FF;
    got = 0;
    sck_in = cpol; ss_n = 1;
    wr(2'd0, {1'b0, 1'b1, 1'b0, 1'b0, cpol, cpha, lsbf, size, 8'd0});
    wr(2'd2, pre);
    repeat (4) @(negedge clk);
    chk(!miso_oe, "R10 unselected", miso_oe, 0);
    ss_n = 0;
    repeat (8) @(negedge clk);
    for (int b = 0; b < n; b++) begin
      p = bpos(lsbf, n, b);
      if (!cpha) begin
        mosi_in = mw[p];
        repeat (8) @(negedge clk);
        got[p] = miso_line;
        sck_in = ~cpol;
        repeat (8) @(negedge clk);
        sck_in = cpol;
        repeat (8) @(negedge clk);
      end else begin
        sck_in = ~cpol;
        repeat (4) @(negedge clk);
        mosi_in = mw[p];
        repeat (8) @(negedge clk);
        got[p] = miso_line;
        sck_in = cpol;
        repeat (8) @(negedge clk);
      end
    end
    ss_n = 1;
    repeat (4) @(negedge clk);
    chk(got == (pre & mask), "R10 slave tx", got, pre & mask);
    rd(2'd1, v);
    chk(v[0] == 1'b1, "R10 slave flag", v[0], 1);
    rd(2'd2, v);
    chk(v == (mw & mask), "R10 slave rx", v, mw & mask);
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    rd(2'd0, v); chk(v == 16'h0400, "R1 ctrl reset", v, 16'h0400);
    rd(2'd1, v); chk(v == 16'h0, "R1 status reset", v, 0);
    rd(2'd2, v); chk(v == 16'h0, "R1 data reset", v, 0);
    chk(!irq, "R1 irq reset", irq, 0);

    wr(2'd0, 16'h1401);
    wr(2'd2, 16'h00FF);
    repeat (20) @(negedge clk);
    chk(!sck_oe && !mosi_oe && !miso_oe, "R2 pins released", {sck_oe, mosi_oe, miso_oe}, 0);
    rd(2'd1, v); chk(v == 16'h0, "R2 no transfer", v, 0);

    wr(2'd0, 16'h7800);
    repeat (2) @(negedge clk);
    chk(!sck_oe, "R7 od released high", sck_oe, 0);
    wr(2'd0, 16'h7000);
    repeat (2) @(negedge clk);
    chk(sck_oe && !sck_out, "R7 od drives low", {sck_oe, sck_out}, 2);

    wr(2'd0, 16'h5500);
    wr(2'd2, 16'h1234);
    repeat (40) @(negedge clk);
    rd(2'd1, v); chk(v == 16'h0, "R8 baud zero", v, 0);

    for (int cfg = 0; cfg < 32; cfg++)
      for (int k = 0; k < 2; k++)
        run_master(cfg[0], cfg[1], cfg[2], cfg[3], cfg[4], (cfg % 3) + 1,
                   16'hA5C3 ^ 16'(cfg * 16'h1357) ^ (k ? 16'hFFFF : 16'h0),
                   16'h3C96 ^ 16'(cfg * 16'h0F21) ^ (k ? 16'h5A5A : 16'h0), 1'b0);

    run_master(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3, 16'hBEEF, 16'h1DEA, 1'b1);

    wr(2'd0, 16'hD504);
    wr(2'd2, 16'hCAFE);
    repeat (20) @(negedge clk);
    wr(2'd0, 16'hD505);
    repeat (2) @(negedge clk);
    rd(2'd1, v); chk(v == 16'h0, "R11 abort clears", v, 0);
    repeat (100) @(negedge clk);
    rd(2'd1, v); chk(v == 16'h0, "R11 no flag after abort", v, 0);

    for (int cfg = 0; cfg < 16; cfg++)
      run_slave(cfg[0], cfg[1], cfg[2], cfg[3],
                16'h9C31 ^ 16'(cfg * 16'h0B17), 16'h4E2D ^ 16'(cfg * 16'h2203));

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog R1-timeout actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule